// File: doc/BRIEF.md
# Occupancy-Ranked Fetch Thread Selector

This block sits in front of the instruction fetch stage of a multithreaded core. On every clock edge it looks at the per-thread occupancy counters kept elsewhere in the pipeline. These counters give, for each thread, the instructions waiting in the front end, the branches not yet resolved and the data-cache misses still outstanding. The block then names up to two hardware threads that may fetch in the following cycle, together with how many instructions each may fetch. A policy input picks the ranking key: the front-end instruction count, the unresolved branch count, the outstanding miss count, or no key at all, which gives plain rotation. In each case the thread with the smallest key wins.

Equal keys are resolved by a rotation pointer. The pointer moves one past the last thread granted, so threads with equal counts take turns and none is left out. An eligibility mask removes stalled or inactive threads from the contest. A configuration input selects one thread with an eight-instruction block, two threads with four-instruction blocks, or two threads with eight-instruction blocks. The result is registered, so the grants seen in a cycle reflect the inputs sampled at the previous edge.

Top module: `fetch_thread_pick`

## Requirements
- R1: While `rst` is high at a clock edge, both grant slots become invalid with length 0 and the rotation pointer returns to thread 0. The first grant after reset, with all threads eligible and equal keys, therefore goes to thread 0.
- R2: Grants are registered. The outputs seen after a rising edge are computed from the inputs sampled at that edge.
- R3: With `policy` = 2'b01, slot 0 goes to the eligible thread with the smallest front-end instruction count (`icnt_flat`).
- R4: With `policy` = 2'b10, slot 0 goes to the eligible thread with the smallest unresolved branch count (`brcnt_flat`).
- R5: With `policy` = 2'b11, slot 0 goes to the eligible thread with the smallest outstanding miss count (`miss_flat`).
- R6: With `policy` = 2'b00, the counters are ignored. Eligible threads are granted in increasing cyclic id order, starting at the rotation pointer.
- R7: Among threads with equal keys, the one reached first when counting upward (mod NUM_THR) from the rotation pointer wins. After any grant the pointer moves to one past the id in the last valid slot (slot 1 if valid, otherwise slot 0). With no grant the pointer holds.
- R8: A thread whose `elig` bit is 0 is never granted. If no thread is eligible both slots are invalid. If only one is eligible, slot 1 is invalid. Slot 1 is never valid while slot 0 is invalid.
- R9: When both slots are valid, their thread ids differ.
- R10: `cfg` = 2'b00 grants one thread (slot 1 always invalid) with length 8. `cfg` = 2'b01 grants up to two threads with length 4 each. `cfg` = 2'b10 or 2'b11 grants up to two threads with length 8 each. An invalid slot has length 0.
- R11: Slot 1 goes to the thread that would win slot 0 if the slot 0 winner were removed: same key, same tie rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| policy | input | 2 | Ranking key: 00 rotation, 01 instruction count, 10 branch count, 11 miss count |
| cfg | input | 2 | Fetch shape: 00 one thread x8, 01 two threads x4, 1x two threads x8 |
| elig | input | NUM_THR | Per-thread eligibility, bit i for thread i |
| icnt_flat | input | NUM_THR*CNT_W | Front-end instruction counts, thread i at bits [i*CNT_W +: CNT_W] |
| brcnt_flat | input | NUM_THR*CNT_W | Unresolved branch counts, same packing |
| miss_flat | input | NUM_THR*CNT_W | Outstanding miss counts, same packing |
| pick0_vld | output | 1 | Slot 0 grant valid |
| pick0_id | output | $clog2(NUM_THR) | Slot 0 thread id |
| pick0_len | output | 4 | Slot 0 fetch block size |
| pick1_vld | output | 1 | Slot 1 grant valid |
| pick1_id | output | $clog2(NUM_THR) | Slot 1 thread id |
| pick1_len | output | 4 | Slot 1 fetch block size |

## Verification
Each grant is due one edge after the inputs that produced it, and the rotation pointer's effect shows on the grant one edge later still. The bench therefore drives a new input set on the falling edge, computes the expected grant from its own pointer model before the next rising edge, and compares at the following falling edge. Only after that comparison does it advance its pointer model. Directed steps cover reset, pure rotation, ties, empty and single-thread eligibility and every `cfg` shape. Random steps use counts drawn from a narrow range so that ties are frequent.

// File: rtl/fetch_thread_pick.sv
module fetch_thread_pick #(
  parameter int NUM_THR = 4,
  parameter int CNT_W   = 6,
  parameter int BLK_WIDE   = 8,
  parameter int BLK_NARROW = 4,
  localparam int IDW = $clog2(NUM_THR),
  localparam int KW  = CNT_W + IDW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               policy,
  input  logic [1:0]               cfg,
  input  logic [NUM_THR-1:0]       elig,
  input  logic [NUM_THR*CNT_W-1:0] icnt_flat,
  input  logic [NUM_THR*CNT_W-1:0] brcnt_flat,
  input  logic [NUM_THR*CNT_W-1:0] miss_flat,
  output logic                     pick0_vld,
  output logic [IDW-1:0]           pick0_id,
  output logic [3:0]               pick0_len,
  output logic                     pick1_vld,
  output logic [IDW-1:0]           pick1_id,
  output logic [3:0]               pick1_len
);

  localparam logic [3:0] LEN_W = 4'(BLK_WIDE);
  localparam logic [3:0] LEN_N = 4'(BLK_NARROW);

  logic [IDW-1:0] ptr;
  logic [KW-1:0]  key [NUM_THR];
  logic [CNT_W-1:0] cnt_sel;
  logic [KW-1:0]  best_a, best_b;
  logic           hit_a, hit_b, take_b;
  logic [IDW-1:0] win_a, win_b, ptr_nxt;
  logic [3:0]     len_nxt;

  always_comb begin
    for (int i = 0; i < NUM_THR; i++) begin
      case (policy)
        2'b01:   cnt_sel = icnt_flat[i*CNT_W +: CNT_W];
        2'b10:   cnt_sel = brcnt_flat[i*CNT_W +: CNT_W];
        2'b11:   cnt_sel = miss_flat[i*CNT_W +: CNT_W];
        default: cnt_sel = '0;
      endcase
      key[i] = {cnt_sel, IDW'((i + NUM_THR - int'(ptr)) % NUM_THR)};
    end
  end

  always_comb begin
    hit_a  = 1'b0;
    best_a = '1;
    win_a  = '0;
    for (int i = 0; i < NUM_THR; i++)
      if (elig[i] && (!hit_a || key[i] < best_a)) begin
        hit_a  = 1'b1;
        best_a = key[i];
        win_a  = IDW'(i);
      end
    hit_b  = 1'b0;
    best_b = '1;
    win_b  = '0;
    for (int i = 0; i < NUM_THR; i++)
      if (elig[i] && IDW'(i) != win_a && (!hit_b || key[i] < best_b)) begin
        hit_b  = 1'b1;
        best_b = key[i];
        win_b  = IDW'(i);
      end
  end

  assign take_b  = hit_a && hit_b && (cfg != 2'b00);
  assign len_nxt = (cfg == 2'b01) ? LEN_N : LEN_W;

  always_comb begin
    ptr_nxt = ptr;
    if (take_b)     ptr_nxt = IDW'((int'(win_b) + 1) % NUM_THR);
    else if (hit_a) ptr_nxt = IDW'((int'(win_a) + 1) % NUM_THR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      pick0_vld <= 1'b0;
      pick0_id  <= '0;
      pick0_len <= '0;
      pick1_vld <= 1'b0;
      pick1_id  <= '0;
      pick1_len <= '0;
    end else begin
      ptr       <= ptr_nxt;
      pick0_vld <= hit_a;
      pick0_id  <= win_a;
      pick0_len <= hit_a ? len_nxt : 4'd0;
      pick1_vld <= take_b;
      pick1_id  <= win_b;
      pick1_len <= take_b ? len_nxt : 4'd0;
    end
  end

  AST_SLOT_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    (pick0_vld && pick1_vld) |-> (pick0_id != pick1_id)); // R9

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
    pick1_vld |-> pick0_vld); // R8

  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |=> !pick0_vld); // R8

  AST_PICK0_ELIG: assert property (@(posedge clk) disable iff (rst)
    pick0_vld |-> |($past(elig) & (NUM_THR'(1) << pick0_id))); // R8

  AST_PICK1_ELIG: assert property (@(posedge clk) disable iff (rst)
    pick1_vld |-> |($past(elig) & (NUM_THR'(1) << pick1_id))); // R8

  AST_SINGLE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (cfg == 2'b00) |=> !pick1_vld); // R10

  AST_NARROW_LEN: assert property (@(posedge clk) disable iff (rst)
    (cfg == 2'b01 && elig != '0) |=> (pick0_len == LEN_N)); // R10

  AST_IDLE_LEN: assert property (@(posedge clk) disable iff (rst)
    !pick0_vld |-> (pick0_len == 4'd0)); // R10

endmodule

// File: tb/sim_fetch_thread_pick.sv
`timescale 1ns/1ps
module sim_fetch_thread_pick;
  localparam int N  = 4;
  localparam int CW = 6;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst;
  logic [1:0] policy, cfg;
  logic [N-1:0] elig;
  logic [N*CW-1:0] icnt_flat, brcnt_flat, miss_flat;
  logic pick0_vld, pick1_vld;
  logic [IW-1:0] pick0_id, pick1_id;
  logic [3:0] pick0_len, pick1_len;

  int checks = 0;
  int fails  = 0;
  int mptr   = 0;

  always #2 clk = ~clk;

  fetch_thread_pick #(.NUM_THR(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .policy(policy), .cfg(cfg), .elig(elig),
    .icnt_flat(icnt_flat), .brcnt_flat(brcnt_flat), .miss_flat(miss_flat),
    .pick0_vld(pick0_vld), .pick0_id(pick0_id), .pick0_len(pick0_len),
    .pick1_vld(pick1_vld), .pick1_id(pick1_id), .pick1_len(pick1_len));

  function automatic int key_of(int t);
    case (policy)
      2'b01:   return int'(icnt_flat[t*CW +: CW]);
      2'b10:   return int'(brcnt_flat[t*CW +: CW]);
      2'b11:   return int'(miss_flat[t*CW +: CW]);
      default: return 0;
    endcase
  endfunction

  // walk threads in rotation order from the pointer, keep the first strict minimum
  function automatic int pick_from(int start, int skip);
    int best = -1;
    int bkey = 0;
    for (int d = 0; d < N; d++) begin
      int t = (start + d) % N;
      if (elig[t] && t != skip && (best < 0 || key_of(t) < bkey)) begin
        best = t;
        bkey = key_of(t);
      end
    end
    return best;
  endfunction

  task automatic set_counts(input int a0, a1, a2, a3, input int sel);
    logic [N*CW-1:0] v;
    v = {CW'(a3), CW'(a2), CW'(a1), CW'(a0)};
    if (sel == 1) icnt_flat = v;
    else if (sel == 2) brcnt_flat = v;
    else miss_flat = v;
  endtask

  task automatic step(input string tag);
    int a, b, len;
    logic ev0, ev1;
    logic [IW-1:0] ei0, ei1;
    logic [3:0] el0, el1;
    a = pick_from(mptr, -1);
    b = (a >= 0 && cfg != 2'b00) ? pick_from(mptr, a) : -1;
    len = (cfg == 2'b01) ? 4 : 8;
    ev0 = (a >= 0); ev1 = (b >= 0);
    ei0 = ev0 ? IW'(a) : '0; ei1 = ev1 ? IW'(b) : '0;
    el0 = ev0 ? 4'(len) : 4'd0; el1 = ev1 ? 4'(len) : 4'd0;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (pick0_vld !== ev0 || (ev0 && pick0_id !== ei0) || pick0_len !== el0 ||
        pick1_vld !== ev1 || (ev1 && pick1_id !== ei1) || pick1_len !== el1) begin
      fails++;
      $display("FAIL %s: got v%0b id%0d len%0d / v%0b id%0d len%0d, exp v%0b id%0d len%0d / v%0b id%0d len%0d",
               tag, pick0_vld, pick0_id, pick0_len, pick1_vld, pick1_id, pick1_len,
               ev0, ei0, el0, ev1, ei1, el1);
    end
    if (ev1) mptr = (b + 1) % N;
    else if (ev0) mptr = (a + 1) % N;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7151));
    rst = 1'b1; policy = 2'b00; cfg = 2'b00; elig = '1;
    icnt_flat = '0; brcnt_flat = '0; miss_flat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pick0_vld !== 1'b0 || pick1_vld !== 1'b0 || pick0_len !== 4'd0 || pick1_len !== 4'd0) begin
      fails++;
      $display("FAIL R1 reset: got v%0b/v%0b len%0d/%0d, exp 0/0 len 0/0",
               pick0_vld, pick1_vld, pick0_len, pick1_len);
    end
    rst = 1'b0;
    mptr = 0;

    // R1 R6: pure rotation from thread 0, one thread per cycle
    step("R1 first grant thread 0");
    for (int k = 0; k < 5; k++) step("R6 rotation single");
    cfg = 2'b10;
    for (int k = 0; k < 3; k++) step("R6 rotation pair");

    // R3 R11: instruction count ranking with ties
    policy = 2'b01;
    set_counts(5, 2, 7, 2, 1);
    step("R3 instruction count pair with tie");
    step("R7 tie order after pointer move");
    // R4 and R5
    policy = 2'b10;
    set_counts(9, 9, 1, 4, 2);
    step("R4 branch count");
    policy = 2'b11;
    set_counts(3, 0, 3, 6, 3);
    step("R5 miss count");
    // R8: eligibility cases
    elig = 4'b0000;
    step("R8 no eligible thread");
    elig = 4'b0100;
    step("R8 single eligible");
    elig = 4'b1010;
    policy = 2'b01;
    set_counts(0, 4, 0, 4, 1);
    step("R8 low counts ineligible");
    // R10: block shapes
    elig = 4'b1111;
    cfg = 2'b01;
    step("R10 two narrow");
    cfg = 2'b11;
    step("R10 two wide alt code");
    cfg = 2'b00;
    step("R10 one wide");
    // R2: single change seen one edge later
    set_counts(1, 1, 0, 1, 1);
    step("R2 registered response");

    // random mix, narrow count range so ties are common (R7 R9 R11)
    for (int k = 0; k < 600; k++) begin
      policy = 2'($urandom_range(0, 3));
      cfg    = 2'($urandom_range(0, 3));
      elig   = N'($urandom_range(0, (1 << N) - 1));
      set_counts($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), 1);
      set_counts($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), 2);
      set_counts($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), 3);
      step("R7 R9 R11 random");
    end

    // R1: reset mid-run returns the pointer to thread 0
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mptr = 0;
    policy = 2'b00; cfg = 2'b00; elig = '1;
    step("R1 pointer back to 0");
    finish_run();
  end
endmodule